// File: doc/BRIEF.md
# PC Sample Register Bank

This block is the register face of a processor's external-debug program-counter sampler. A debugger reaches it over a plain 32-bit register bus that accepts one read or one write per cycle. On the core side it watches the live program counter, context ID, virtual-machine ID, security and exception-level state, and the core's power and double-lock status.

The central behaviour is a snapshot taken as a side effect of reading. Reading the low program-counter word returns the live low half. In the same clock edge it freezes the upper program-counter half, the context ID and the packed VM/state word into sample registers. Later reads of those registers therefore describe the same moment as the low word, even if the core has moved on. When the core is halted in debug or sampling is prohibited, the low word reads as all ones and the snapshot is left alone. Every sample register reads zero, with no capture, unless the core is powered, not double-locked, and the software OS lock has been released.

The bank also holds a two-bit power control register that drives request outputs, an OS lock that a write of zero opens, a read-only power status word and two device identification words. Read data appears on the bus one cycle after the read request and holds until the next read.

Top module: `pcsamp_regbank`

## Requirements
- R1: After reset, bus_rdata is zero, both power request outputs are low and the OS lock is set.
- R2: A permitted read of offset 0x0A0 while sampling is allowed returns core_pc[31:0]. In the same edge it captures the upper PC half (offset 0x0AC), core_ctxid (offset 0x0A4) and the packed VM/state word (offset 0x0A8). Later reads of these return the captured values until the next capture.
- R3: A read of offset 0x0A0 while core_halted or sample_prohibit is high returns 0xFFFFFFFF and leaves all three captured registers unchanged.
- R4: A sample register (0x0A0, 0x0A4, 0x0A8, 0x0AC) is permitted only when core_pwr_up is high, core_dlock is low and the OS lock is clear. Otherwise its read returns zero and updates no captured register.
- R5: The VM/state word at 0x0A8 holds core_nonsec in bit 31, core_el2 in bit 30, core_el3 in bit 29, core_aa64 in bit 28 and core_vmid in bits 7:0, with all other bits zero.
- R6: The power control register at 0x310 keeps written bits 3 and 0, which drive pwr_up_req and no_pwrdn_req respectively. Its other bits read zero.
- R7: The power status word at 0x314 reads core_pwr_up in bit 0, the OS lock in bit 5 and core_dlock in bit 6, with other bits zero.
- R8: Writing zero to offset 0x300 clears the OS lock, and writing any nonzero value sets it. Offset 0x300 reads zero.
- R9: Offset 0xFC8 reads SAMPLE_MODE in bits 3:0 and offset 0xFC4 reads OFFSET_MODE in bits 3:0, with other bits zero.
- R10: When SAMPLE_MODE is below 2 the context ID register reads zero. When it is below 3 the VM/state register reads zero.
- R11: Reads of unmapped offsets return zero. Writes to read-only offsets (sample, status, identification) change nothing that can be read.
- R12: Read data appears on bus_rdata one cycle after a read request and holds its value in cycles without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request this cycle |
| bus_wr | input | 1 | Write request this cycle |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| core_pc | input | PC_W | Live program counter |
| core_ctxid | input | 32 | Live context ID |
| core_vmid | input | 8 | Live virtual-machine ID |
| core_nonsec | input | 1 | Core is in non-secure state |
| core_el2 | input | 1 | Core is at exception level 2 |
| core_el3 | input | 1 | Core is at exception level 3 |
| core_aa64 | input | 1 | Core runs in 64-bit state |
| core_pwr_up | input | 1 | Core power domain is up |
| core_dlock | input | 1 | OS double lock is set |
| core_halted | input | 1 | Core is halted in debug state |
| sample_prohibit | input | 1 | Sample-based profiling is prohibited |
| pwr_up_req | output | 1 | Core power-up request |
| no_pwrdn_req | output | 1 | Core no-powerdown request |

## Verification
The assertions assume that a read and a write never fall in the same cycle, that core inputs are steady around each rising edge, and that the bus is idle during reset. The stimulus raises at most one request per cycle and drives every input only at falling edges. A second instance with the smallest sampling mode shares all inputs with the main instance, so that both see identical traffic. The captured-register checks change the live core values between the capturing read and the follow-up reads. A stale or overwritten capture therefore shows at the ports.

// File: rtl/pcsamp_pkg.sv
package pcsamp_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 32;
    localparam int VMID_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PC_LO   = 12'h0A0;
    localparam logic [ADDR_W-1:0] OFS_CTX     = 12'h0A4;
    localparam logic [ADDR_W-1:0] OFS_VMSTATE = 12'h0A8;
    localparam logic [ADDR_W-1:0] OFS_PC_HI   = 12'h0AC;
    localparam logic [ADDR_W-1:0] OFS_OSLOCK  = 12'h300;
    localparam logic [ADDR_W-1:0] OFS_PWRCTL  = 12'h310;
    localparam logic [ADDR_W-1:0] OFS_PWRSTAT = 12'h314;
    localparam logic [ADDR_W-1:0] OFS_ID1     = 12'hFC4;
    localparam logic [ADDR_W-1:0] OFS_ID0     = 12'hFC8;

    localparam logic [WORD_W-1:0] PROHIBITED_WORD = '1;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PC_LO,
        SEL_CTX,
        SEL_VMSTATE,
        SEL_PC_HI,
        SEL_OSLOCK,
        SEL_PWRCTL,
        SEL_PWRSTAT,
        SEL_ID1,
        SEL_ID0
    } reg_sel_e;

    typedef struct packed {
        logic              nonsec;
        logic              el2;
        logic              el3;
        logic              aa64;
        logic [VMID_W-1:0] vmid;
    } vstate_t;

    typedef struct packed {
        logic [WORD_W-1:0] pc_hi;
        logic [WORD_W-1:0] ctxid;
        logic [WORD_W-1:0] vmstate;
    } snap_t;

    function automatic logic [WORD_W-1:0] pack_vmstate(vstate_t v);
        return {v.nonsec, v.el2, v.el3, v.aa64, {(WORD_W-4-VMID_W){1'b0}}, v.vmid};
    endfunction

    function automatic reg_sel_e decode_offset(logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_PC_LO:   s = SEL_PC_LO;
            OFS_CTX:     s = SEL_CTX;
            OFS_VMSTATE: s = SEL_VMSTATE;
            OFS_PC_HI:   s = SEL_PC_HI;
            OFS_OSLOCK:  s = SEL_OSLOCK;
            OFS_PWRCTL:  s = SEL_PWRCTL;
            OFS_PWRSTAT: s = SEL_PWRSTAT;
            OFS_ID1:     s = SEL_ID1;
            OFS_ID0:     s = SEL_ID0;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_sample(reg_sel_e s);
        return (s == SEL_PC_LO) || (s == SEL_CTX) ||
               (s == SEL_VMSTATE) || (s == SEL_PC_HI);
    endfunction

endpackage

// File: rtl/pcsamp_decode.sv
module pcsamp_decode
    import pcsamp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic              sample_sel
);

    always_comb begin
        sel        = decode_offset(addr);
        sample_sel = is_sample(sel);
    end

endmodule

// File: rtl/pcsamp_snapshot.sv
module pcsamp_snapshot
    import pcsamp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_en,
    input  snap_t live,
    output snap_t held
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (cap_en) begin
            held <= live;
        end
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(held));                              // R4

    AST_SNAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (held == $past(live)));                       // R2

endmodule

// File: rtl/pcsamp_pwrlock.sv
module pcsamp_pwrlock
    import pcsamp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output logic              pwr_up_req,
    output logic              no_pwrdn_req,
    output logic              os_lock
);

    localparam int BIT_UPREQ = 3;
    localparam int BIT_NOPD  = 0;

    logic wr_ctl;
    logic wr_lock;

    always_comb begin
        wr_ctl  = wr_en && (sel == SEL_PWRCTL);
        wr_lock = wr_en && (sel == SEL_OSLOCK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_up_req   <= 1'b0;
            no_pwrdn_req <= 1'b0;
            os_lock      <= 1'b1;
        end else begin
            if (wr_ctl) begin
                pwr_up_req   <= wdata[BIT_UPREQ];
                no_pwrdn_req <= wdata[BIT_NOPD];
            end
            if (wr_lock) begin
                os_lock <= |wdata;
            end
        end
    end

    AST_OSLOCK_OPEN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_OSLOCK && wdata == '0) |=> !os_lock);   // R8

    AST_PWRCTL_KEEP: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && sel == SEL_PWRCTL) |=> ($stable(pwr_up_req) && $stable(no_pwrdn_req))); // R6

endmodule

// File: rtl/pcsamp_regbank.sv
module pcsamp_regbank
    import pcsamp_pkg::*;
#(
    parameter int PC_W        = 64,
    parameter int SAMPLE_MODE = 3,
    parameter int OFFSET_MODE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [11:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PC_W-1:0]   core_pc,
    input  logic [31:0]       core_ctxid,
    input  logic [7:0]        core_vmid,
    input  logic              core_nonsec,
    input  logic              core_el2,
    input  logic              core_el3,
    input  logic              core_aa64,
    input  logic              core_pwr_up,
    input  logic              core_dlock,
    input  logic              core_halted,
    input  logic              sample_prohibit,
    output logic              pwr_up_req,
    output logic              no_pwrdn_req
);

    localparam int          HI_W      = PC_W - WORD_W;
    localparam bit          CTX_IMPL  = (SAMPLE_MODE >= 2);
    localparam bit          VMS_IMPL  = (SAMPLE_MODE >= 3);
    localparam logic [3:0]  MODE_NIB  = 4'(SAMPLE_MODE);
    localparam logic [3:0]  OFS_NIB   = 4'(OFFSET_MODE);

    reg_sel_e          sel;
    logic              sample_sel;
    logic              os_lock;
    logic              permitted;
    logic              prohibited;
    logic              cap_en;
    vstate_t           vlive;
    snap_t             live;
    snap_t             held;
    logic [WORD_W-1:0] ctx_view;
    logic [WORD_W-1:0] vms_view;
    logic [WORD_W-1:0] rd_next;

    pcsamp_decode u_decode (
        .addr       (bus_addr),
        .sel        (sel),
        .sample_sel (sample_sel)
    );

    pcsamp_pwrlock u_pwrlock (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (bus_wr),
        .sel          (sel),
        .wdata        (bus_wdata),
        .pwr_up_req   (pwr_up_req),
        .no_pwrdn_req (no_pwrdn_req),
        .os_lock      (os_lock)
    );

    always_comb begin
        vlive.nonsec = core_nonsec;
        vlive.el2    = core_el2;
        vlive.el3    = core_el3;
        vlive.aa64   = core_aa64;
        vlive.vmid   = core_vmid;
        live.pc_hi   = WORD_W'(core_pc[PC_W-1:WORD_W]);
        live.ctxid   = core_ctxid;
        live.vmstate = pack_vmstate(vlive);
        permitted    = core_pwr_up && !core_dlock && !os_lock;
        prohibited   = core_halted || sample_prohibit;
        cap_en       = bus_rd && (sel == SEL_PC_LO) && permitted && !prohibited;
    end

    pcsamp_snapshot u_snapshot (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .live   (live),
        .held   (held)
    );

    generate
        if (CTX_IMPL) begin : g_ctx_on
            assign ctx_view = held.ctxid;
        end else begin : g_ctx_off
            assign ctx_view = '0;
        end
        if (VMS_IMPL) begin : g_vms_on
            assign vms_view = held.vmstate;
        end else begin : g_vms_off
            assign vms_view = '0;
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        unique case (sel)
            SEL_PC_LO: begin
                if (permitted) begin
                    rd_next = prohibited ? PROHIBITED_WORD : core_pc[WORD_W-1:0];
                end
            end
            SEL_PC_HI:   rd_next = permitted ? held.pc_hi : '0;
            SEL_CTX:     rd_next = permitted ? ctx_view : '0;
            SEL_VMSTATE: rd_next = permitted ? vms_view : '0;
            SEL_PWRCTL:  rd_next = {28'h0, pwr_up_req, 2'b00, no_pwrdn_req};
            SEL_PWRSTAT: rd_next = {25'h0, core_dlock, os_lock, 4'h0, core_pwr_up};
            SEL_ID0:     rd_next = {28'h0, MODE_NIB};
            SEL_ID1:     rd_next = {28'h0, OFS_NIB};
            SEL_OSLOCK:  rd_next = '0;
            SEL_NONE:    rd_next = '0;
            default:     rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_next;
        end
    end

    initial begin
        AST_PC_WIDTH: assert (HI_W > 0 && HI_W <= WORD_W);
    end

    AST_PROHIB_ONES: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_PC_LO && permitted && (core_halted || sample_prohibit))
        |=> (bus_rdata == 32'hFFFF_FFFF));                           // R3

    AST_NOPERM_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sample_sel && !(core_pwr_up && !core_dlock && !os_lock))
        |=> (bus_rdata == '0));                                      // R4

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));          // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));                             // R12

endmodule

// File: tb/pcsamp_regbank_tb.sv
module pcsamp_regbank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_rd, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata, rdata_min;
    logic [63:0] core_pc;
    logic [31:0] core_ctxid;
    logic [7:0]  core_vmid;
    logic        core_nonsec, core_el2, core_el3, core_aa64;
    logic        core_pwr_up, core_dlock, core_halted, sample_prohibit;
    logic        pwr_up_req, no_pwrdn_req, pur_min, npd_min;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;
    logic [31:0] last_min;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcsamp_regbank u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_pc(core_pc), .core_ctxid(core_ctxid), .core_vmid(core_vmid),
        .core_nonsec(core_nonsec), .core_el2(core_el2), .core_el3(core_el3),
        .core_aa64(core_aa64), .core_pwr_up(core_pwr_up), .core_dlock(core_dlock),
        .core_halted(core_halted), .sample_prohibit(sample_prohibit),
        .pwr_up_req(pwr_up_req), .no_pwrdn_req(no_pwrdn_req)
    );

    pcsamp_regbank #(.SAMPLE_MODE(1), .OFFSET_MODE(2)) u_dut_min (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_min),
        .core_pc(core_pc), .core_ctxid(core_ctxid), .core_vmid(core_vmid),
        .core_nonsec(core_nonsec), .core_el2(core_el2), .core_el3(core_el3),
        .core_aa64(core_aa64), .core_pwr_up(core_pwr_up), .core_dlock(core_dlock),
        .core_halted(core_halted), .sample_prohibit(sample_prohibit),
        .pwr_up_req(pur_min), .no_pwrdn_req(npd_min)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
        last_min = rdata_min;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 rdata at reset", bus_rdata, 32'h0);
        check("R1 request outputs at reset", {30'h0, pwr_up_req, no_pwrdn_req}, 32'h0);
        rd(12'h314, d);
        check("R1 R7 status with lock set", d, 32'h0000_0021);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(12'h300, 32'h1);
        rd(12'h314, d);
        check("R8 nonzero sets lock", d, 32'h0000_0021);
        wr(12'h300, 32'h0);
        rd(12'h314, d);
        check("R8 zero clears lock", d, 32'h0000_0001);
        rd(12'h300, d);
        check("R8 lock offset reads zero", d, 32'h0);
        core_dlock = 1'b1;
        rd(12'h314, d);
        check("R7 double lock bit 6", d, 32'h0000_0041);
        core_dlock = 1'b0; core_pwr_up = 1'b0;
        rd(12'h314, d);
        check("R7 power down", d, 32'h0);
        core_pwr_up = 1'b1;
    endtask

    task automatic t_snapshot();
        logic [31:0] d;
        core_pc = 64'h1234_5678_9ABC_DEF1; core_ctxid = 32'hC0DE_0042;
        core_nonsec = 1; core_el2 = 0; core_el3 = 1; core_aa64 = 1; core_vmid = 8'h5A;
        rd(12'h0A0, d);
        check("R2 low word live", d, 32'h9ABC_DEF1);
        core_pc = 64'hAAAA_BBBB_CCCC_DDDD; core_ctxid = 32'h1111_1111;
        core_nonsec = 0; core_el3 = 0; core_el2 = 1; core_vmid = 8'h03;
        rd(12'h0AC, d);
        check("R2 high word captured", d, 32'h1234_5678);
        rd(12'h0A4, d);
        check("R2 context captured", d, 32'hC0DE_0042);
        check("R10 context absent in mode 1", last_min, 32'h0);
        rd(12'h0A8, d);
        check("R5 vm state packing", d, 32'hB000_005A);
        check("R10 vm state absent in mode 1", last_min, 32'h0);
    endtask

    task automatic t_prohibit();
        logic [31:0] d;
        sample_prohibit = 1'b1;
        rd(12'h0A0, d);
        check("R3 prohibited reads ones", d, 32'hFFFF_FFFF);
        sample_prohibit = 1'b0; core_halted = 1'b1;
        rd(12'h0A0, d);
        check("R3 halted reads ones", d, 32'hFFFF_FFFF);
        core_halted = 1'b0;
        rd(12'h0AC, d);
        check("R3 capture kept", d, 32'h1234_5678);
    endtask

    task automatic t_noperm();
        logic [31:0] d;
        core_pwr_up = 1'b0;
        rd(12'h0A0, d);
        check("R4 powered off low word", d, 32'h0);
        core_pwr_up = 1'b1; core_dlock = 1'b1;
        rd(12'h0A0, d);
        check("R4 double lock low word", d, 32'h0);
        rd(12'h0AC, d);
        check("R4 double lock high word", d, 32'h0);
        core_dlock = 1'b0;
        wr(12'h300, 32'h5);
        rd(12'h0A0, d);
        check("R4 os lock low word", d, 32'h0);
        wr(12'h300, 32'h0);
        rd(12'h0AC, d);
        check("R4 no capture while denied", d, 32'h1234_5678);
    endtask

    task automatic t_pwrctl();
        logic [31:0] d;
        wr(12'h310, 32'hFFFF_FFFF);
        rd(12'h310, d);
        check("R6 only bits 3 and 0 kept", d, 32'h0000_0009);
        check("R6 both requests driven", {30'h0, pwr_up_req, no_pwrdn_req}, 32'h3);
        wr(12'h310, 32'h0000_0008);
        check("R6 up request alone", {30'h0, pwr_up_req, no_pwrdn_req}, 32'h2);
    endtask

    task automatic t_ident();
        logic [31:0] d;
        rd(12'hFC8, d);
        check("R9 sampling mode", d, 32'h3);
        check("R10 mode 1 instance id", last_min, 32'h1);
        rd(12'hFC4, d);
        check("R9 offset mode", d, 32'h1);
    endtask

    task automatic t_readonly();
        logic [31:0] d;
        wr(12'h0AC, 32'hDEAD_BEEF);
        wr(12'h314, 32'hFFFF_FFFF);
        wr(12'hFC8, 32'hF);
        rd(12'h0AC, d);
        check("R11 high word write ignored", d, 32'h1234_5678);
        rd(12'h314, d);
        check("R11 status write ignored", d, 32'h0000_0001);
        rd(12'hFC8, d);
        check("R11 id write ignored", d, 32'h3);
        rd(12'h200, d);
        check("R11 unmapped reads zero", d, 32'h0);
        rd(12'h0A2, d);
        check("R11 misaligned reads zero", d, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        rd(12'hFC8, d);
        core_pc = 64'h0; core_pwr_up = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 read data held", bus_rdata, 32'h3);
        core_pwr_up = 1'b1;
    endtask

    initial begin
        rst = 1; bus_rd = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        core_pc = '0; core_ctxid = '0; core_vmid = '0;
        core_nonsec = 0; core_el2 = 0; core_el3 = 0; core_aa64 = 0;
        core_pwr_up = 1; core_dlock = 0; core_halted = 0; sample_prohibit = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_lock();
        t_snapshot();
        t_prohibit();
        t_noperm();
        t_pwrctl();
        t_ident();
        t_readonly();
        t_hold();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule